// File: doc/BRIEF.md
# Fall-Through Word Queue with Serial Output Register

This block is a first-in first-out queue of 4-bit words built as a column of slots with no read or write pointers. A word written into the top slot moves down one slot per system clock whenever the slot beneath it is free at the start of that cycle. It stops wherever the slot below is still occupied. The top slot accepts a new word only while it is empty, and its empty state is shown on a status output so a producer can pace its writes.

A word that reaches the bottom slot moves into an output register, but only while the active-low transfer input is held low and the output register is empty. Once the register holds a word, its full flag goes high. The word then leaves one bit at a time, least significant bit first, on each falling edge of the serial output clock seen while the serial enable is low. The full flag drops after the last bit, and the next bottom word can enter on the following cycle. The serial data pin is modelled as a data bit plus a drive-enable, so a bus that can be released is built outside the block.

The output register is a three-state machine. OR_IDLE means the register is empty. OR_LOADED means it holds a word from which no bit has been sent. OR_SHIFTING means at least one bit has been sent. The transitions are: take a bottom word (OR_IDLE to OR_LOADED), first shift (OR_LOADED to OR_SHIFTING), further shift (OR_SHIFTING to OR_SHIFTING), and last shift (OR_SHIFTING to OR_IDLE). Master reset forces OR_IDLE and clears every slot.

Top module: `ftq_core`

## Requirements
- R1: While `mrst_n` is low and afterwards until the first write, `top_empty` is 1 and `out_full` is 0, and the queue holds no words.
- R2: A write strobe is taken only when `top_empty` is 1. A strobe while the top slot is occupied is dropped, and its word never appears at the output. Once 16 words are held with transfer blocked, `top_empty` stays 0.
- R3: With the queue empty and `xfer_n` low, `out_full` rises on the 16th clock edge after the edge that takes the write, which is the depth of the column.
- R4: While `xfer_n` is high, a word stays in the bottom slot and `out_full` stays 0. On the first edge with `xfer_n` low, the word enters the output register.
- R5: Once loaded, the output register keeps its word and `out_full` stays 1 until all four bits have been shifted out.
- R6: Bit 0 of the held word appears first on `so_data`. One bit is shifted per falling edge of `so_clk` seen while `so_en_n` is low. Edges seen while `so_en_n` is high shift nothing.
- R7: `out_full` goes to 0 on the edge that shifts the fourth bit. If the bottom slot holds a word and `xfer_n` is low, `out_full` is 1 again one cycle later.
- R8: Words leave in the order they were written, and none is lost or duplicated.
- R9: `so_drv` equals the inverse of `so_oe_n`. While `so_drv` is 0, `so_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| ld_stb | input | 1 | Write strobe for the top slot |
| ld_word | input | 4 | Word to write |
| top_empty | output | 1 | High when the top slot can take a word |
| xfer_n | input | 1 | Active-low permission to move the bottom word into the output register |
| out_full | output | 1 | High while the output register holds a word |
| so_clk | input | 1 | Serial output clock; falling edges are detected in the system clock |
| so_en_n | input | 1 | Active-low serial output enable |
| so_oe_n | input | 1 | Active-low drive enable for the serial data pin |
| so_data | output | 1 | Serial data bit |
| so_drv | output | 1 | High when `so_data` is driven |

## Verification
The assertions assume that `so_clk` changes no faster than the system clock, so that each falling edge lasts at least one cycle high and one cycle low. The stimulus holds every serial clock level for a full system cycle. The assertions also assume that the strobe and transfer inputs are stable at each rising clock edge. The bench changes every input only on the falling edge of `clk`, and it holds `ld_stb` low during reset so that the word-count check starts from an empty column.

// File: rtl/ftq_pkg.sv
package ftq_pkg;

    localparam int unsigned FTQ_WORD_W = 4;
    localparam int unsigned FTQ_DEPTH  = 16;

    typedef enum logic [1:0] {
        OR_IDLE      = 2'd0,
        OR_LOADED    = 2'd1,
        OR_SHIFTING  = 2'd2
    } or_state_t;

endpackage

// File: rtl/ftq_column.sv
module ftq_column
    import ftq_pkg::*;
#(
    parameter int unsigned DEPTH  = FTQ_DEPTH,
    parameter int unsigned WORD_W = FTQ_WORD_W
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              ld_stb,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              pop,
    output logic              top_empty,
    output logic              bot_valid,
    output logic [WORD_W-1:0] bot_word
);

    localparam int unsigned BOT = DEPTH - 1;

    logic [DEPTH-1:0]  vld;
    logic [DEPTH-1:0]  vld_nx;
    logic [DEPTH-1:0]  mv;
    logic [DEPTH-1:0]  fill;
    logic [WORD_W-1:0] slot_word [DEPTH];
    logic              ld_ok;

    assign ld_ok = ld_stb & ~vld[0];

    // a slot moves down when the slot below is free at the start of the cycle
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            if (i == BOT) begin : g_bottom
                assign mv[i] = pop;
            end else begin : g_inner
                assign mv[i] = vld[i] & ~vld[i+1];
            end
            if (i == 0) begin : g_top
                assign fill[i] = ld_ok;
            end else begin : g_below
                assign fill[i] = mv[i-1];
            end
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_nx[i] = (vld[i] & ~mv[i]) | fill[i];
        end
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            vld <= '0;
        end else begin
            vld <= vld_nx;
        end
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_word[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (fill[i]) begin
                    slot_word[i] <= (i == 0) ? ld_word : slot_word[i-1];
                end
            end
        end
    end

    assign top_empty = ~vld[0];
    assign bot_valid = vld[BOT];
    assign bot_word  = slot_word[BOT];

    // R2: a strobe against a blocked top slot leaves that slot untouched
    p_ignore_full_r2: assert property (@(posedge clk) disable iff (!mrst_n)
        (ld_stb && vld[0] && vld[1]) |=> (vld[0] && $stable(slot_word[0])));

    // R4: the bottom word waits while it is not taken
    p_bottom_pause_r4: assert property (@(posedge clk) disable iff (!mrst_n)
        (vld[BOT] && !pop) |=> (vld[BOT] && $stable(slot_word[BOT])));

    // R8: the word count changes only by writes taken and words popped
    p_conserve_r8: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> ($countones(vld) ==
                    $countones($past(vld)) + int'($past(ld_ok)) - int'($past(pop))));

endmodule

// File: rtl/ftq_fall_det.sv
module ftq_fall_det (
    input  logic clk,
    input  logic mrst_n,
    input  logic lvl,
    output logic fall
);

    logic lvl_q;

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl;
        end
    end

    assign fall = lvl_q & ~lvl;

endmodule

// File: rtl/ftq_outreg.sv
module ftq_outreg
    import ftq_pkg::*;
#(
    parameter int unsigned WORD_W = FTQ_WORD_W
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              bot_valid,
    input  logic [WORD_W-1:0] bot_word,
    input  logic              xfer_n,
    input  logic              shift_go,
    output logic              take,
    output logic              full,
    output logic              sbit
);

    localparam int unsigned         CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0]    LAST  = CNT_W'(WORD_W - 1);

    or_state_t         state, state_nx;
    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  cnt;

    // state register
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            state <= OR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            OR_IDLE: begin
                if (take) state_nx = OR_LOADED;
            end
            OR_LOADED: begin
                if (shift_go) state_nx = OR_SHIFTING;
            end
            OR_SHIFTING: begin
                if (shift_go && cnt == LAST) state_nx = OR_IDLE;
            end
            default: state_nx = OR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take = 1'b0;
        full = 1'b0;
        unique case (state)
            OR_IDLE:     take = bot_valid & ~xfer_n;
            OR_LOADED:   full = 1'b1;
            OR_SHIFTING: full = 1'b1;
            default:     full = 1'b0;
        endcase
    end

    assign sbit = sreg[0];

    // data path
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (take) begin
            sreg <= bot_word;
            cnt  <= '0;
        end else if (state != OR_IDLE && shift_go) begin
            sreg <= sreg >> 1;
            cnt  <= cnt + 1'b1;
        end
    end

    // R5: without a shift request a held word is kept
    p_hold_r5: assert property (@(posedge clk) disable iff (!mrst_n)
        (state != OR_IDLE && !shift_go) |=> (state != OR_IDLE && $stable(sreg)));

    // R6: each shift presents the next higher bit
    p_shift_lsb_r6: assert property (@(posedge clk) disable iff (!mrst_n)
        (state != OR_IDLE && shift_go) |=> (sreg == ($past(sreg) >> 1)));

    // R7: the register is empty after its last bit
    p_empty_after_last_r7: assert property (@(posedge clk) disable iff (!mrst_n)
        (state == OR_SHIFTING && shift_go && cnt == LAST) |=> (state == OR_IDLE));

endmodule

// File: rtl/ftq_core.sv
module ftq_core
    import ftq_pkg::*;
#(
    parameter int unsigned DEPTH  = FTQ_DEPTH,
    parameter int unsigned WORD_W = FTQ_WORD_W
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              ld_stb,
    input  logic [WORD_W-1:0] ld_word,
    output logic              top_empty,
    input  logic              xfer_n,
    output logic              out_full,
    input  logic              so_clk,
    input  logic              so_en_n,
    input  logic              so_oe_n,
    output logic              so_data,
    output logic              so_drv
);

    logic              pop;
    logic              bot_valid;
    logic [WORD_W-1:0] bot_word;
    logic              so_fall;
    logic              sbit;

    ftq_column #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_column (
        .clk       (clk),
        .mrst_n    (mrst_n),
        .ld_stb    (ld_stb),
        .ld_word   (ld_word),
        .pop       (pop),
        .top_empty (top_empty),
        .bot_valid (bot_valid),
        .bot_word  (bot_word)
    );

    ftq_fall_det u_fall (
        .clk    (clk),
        .mrst_n (mrst_n),
        .lvl    (so_clk),
        .fall   (so_fall)
    );

    ftq_outreg #(.WORD_W(WORD_W)) u_outreg (
        .clk       (clk),
        .mrst_n    (mrst_n),
        .bot_valid (bot_valid),
        .bot_word  (bot_word),
        .xfer_n    (xfer_n),
        .shift_go  (so_fall & ~so_en_n),
        .take      (pop),
        .full      (out_full),
        .sbit      (sbit)
    );

    assign so_drv  = ~so_oe_n;
    assign so_data = so_drv & sbit;

    // R4: the output register fills only after transfer was allowed
    p_pop_needs_xfer_r4: assert property (@(posedge clk) disable iff (!mrst_n)
        $rose(out_full) |-> $past(!xfer_n));

endmodule

// File: tb/test_ftq_core.sv
module test_ftq_core;

    logic       clk = 1'b0;
    logic       mrst_n;
    logic       ld_stb;
    logic [3:0] ld_word;
    logic       top_empty;
    logic       xfer_n;
    logic       out_full;
    logic       so_clk;
    logic       so_en_n;
    logic       so_oe_n;
    logic       so_data;
    logic       so_drv;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ftq_core i_ftq_core (
        .clk       (clk),
        .mrst_n    (mrst_n),
        .ld_stb    (ld_stb),
        .ld_word   (ld_word),
        .top_empty (top_empty),
        .xfer_n    (xfer_n),
        .out_full  (out_full),
        .so_clk    (so_clk),
        .so_en_n   (so_en_n),
        .so_oe_n   (so_oe_n),
        .so_data   (so_data),
        .so_drv    (so_drv)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [3:0] w);
        for (int i = 0; i < 64 && !top_empty; i++) @(negedge clk);
        ld_stb  = 1'b1;
        ld_word = w;
        @(negedge clk);
        ld_stb  = 1'b0;
    endtask

    task automatic wait_full();
        for (int i = 0; i < 64 && !out_full; i++) @(negedge clk);
    endtask

    // one falling edge of the serial clock, checked half a cycle later
    task automatic pulse_so();
        so_clk = 1'b1;
        @(negedge clk);
        so_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic shift_out(input logic [3:0] w);
        chk(out_full == 1'b1, "R5 full before shift", int'(out_full), 1);
        for (int b = 0; b < 4; b++) begin
            chk(so_data == w[b], "R6 lsb-first bit", int'(so_data), int'(w[b]));
            if (b > 0) chk(out_full == 1'b1, "R5 full mid-word", int'(out_full), 1);
            pulse_so();
        end
        chk(out_full == 1'b0, "R7 empty after fourth bit", int'(out_full), 0);
    endtask

    task automatic t_reset();
        mrst_n = 1'b0;
        idle(3);
        chk(top_empty == 1'b1, "R1 top empty in reset", int'(top_empty), 1);
        chk(out_full == 1'b0, "R1 out empty in reset", int'(out_full), 0);
        mrst_n = 1'b1;
        idle(2);
        chk(top_empty == 1'b1, "R1 top empty after reset", int'(top_empty), 1);
        chk(out_full == 1'b0, "R1 out empty after reset", int'(out_full), 0);
        chk(so_data == 1'b0, "R1 data low after reset", int'(so_data), 0);
    endtask

    task automatic t_latency_r3();
        xfer_n = 1'b0;
        load(4'hA);
        for (int c = 1; c <= 17; c++) begin
            if (c > 1) @(negedge clk);
            chk(out_full == (c == 17), "R3 fall-through latency", int'(out_full), int'(c == 17));
        end
        shift_out(4'hA);
    endtask

    task automatic t_enable_r6_r9();
        load(4'h5);
        wait_full();
        so_en_n = 1'b1;
        for (int i = 0; i < 3; i++) pulse_so();
        chk(so_data == 1'b1, "R6 no shift while disabled", int'(so_data), 1);
        chk(out_full == 1'b1, "R6 still full while disabled", int'(out_full), 1);
        so_en_n = 1'b0;
        so_oe_n = 1'b1;
        @(negedge clk);
        chk(so_drv == 1'b0, "R9 drive off", int'(so_drv), 0);
        chk(so_data == 1'b0, "R9 data low when released", int'(so_data), 0);
        so_oe_n = 1'b0;
        @(negedge clk);
        chk(so_drv == 1'b1, "R9 drive on", int'(so_drv), 1);
        shift_out(4'h5);
    endtask

    task automatic t_hold_r4();
        xfer_n = 1'b1;
        load(4'h3);
        idle(40);
        chk(out_full == 1'b0, "R4 held while transfer blocked", int'(out_full), 0);
        chk(top_empty == 1'b1, "R4 word fell to bottom", int'(top_empty), 1);
        xfer_n = 1'b0;
        @(negedge clk);
        chk(out_full == 1'b1, "R4 taken one edge after release", int'(out_full), 1);
        shift_out(4'h3);
    endtask

    task automatic t_fill_r2_r8();
        xfer_n = 1'b1;
        for (int i = 0; i < 16; i++) load(4'(i ^ 6));
        idle(40);
        chk(top_empty == 1'b0, "R2 top occupied when full", int'(top_empty), 0);
        ld_stb  = 1'b1;
        ld_word = 4'hF;
        @(negedge clk);
        ld_stb  = 1'b0;
        idle(4);
        chk(top_empty == 1'b0, "R2 still full after dropped strobe", int'(top_empty), 0);
        xfer_n = 1'b0;
        wait_full();
        for (int i = 0; i < 16; i++) begin
            shift_out(4'(i ^ 6));
            if (i < 15) begin
                @(negedge clk);
                chk(out_full == 1'b1, "R7 refill next cycle", int'(out_full), 1);
            end
        end
        idle(40);
        chk(out_full == 1'b0, "R2 dropped word never appears", int'(out_full), 0);
        chk(top_empty == 1'b1, "R8 queue drained", int'(top_empty), 1);
    endtask

    initial begin
        mrst_n  = 1'b0;
        ld_stb  = 1'b0;
        ld_word = 4'h0;
        xfer_n  = 1'b0;
        so_clk  = 1'b0;
        so_en_n = 1'b0;
        so_oe_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency_r3();
        t_enable_r6_r9();
        t_hold_r4();
        t_fill_r2_r8();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule